// File: doc/BRIEF.md
# Quadrant-Keyed DDS Phase Generator

This block produces the phase sequence for a direct digital synthesiser. A 48-bit accumulator advances every clock by a tuning word. The tuning word is the sum of up to three frequency words. The base word is always included. The offset word can be gated by a pin, which suits frequency-shift keying. The serial-path word can be gated by a control bit. The top 14 bits of the accumulator, rotated by a quarter-turn multiple chosen by two pins, drive a downstream sine table. The two pins support phase-shift keying or a quadrature pair.

Software writes the base and offset words one byte at a time through a plain parallel register port. An upstream serial receiver delivers the serial word whole. All of these writes land in shadow copies. The words used by the accumulator change only on an update event. An update event is a rising edge on the synchronised update pin, or a write of any data to the update address. Every pin that controls the block passes through a flop synchroniser. The write port and the pins are plain control. The phase output is a free-running sample every clock and has no handshake.

Top module: `dds_phase_core`

## Requirements
- R1: While `rst_n` is low, `phase_out` is 0. After reset, with no writes, the phase advances by 4096 per clock. This is because the base word resets to bit 46 alone, the offset word resets to zero, and the serial enable bit resets to 1.
- R2: Each clock the accumulator adds, modulo 2^48, base + offset (when enabled) + serial (when enabled). `phase_out` presents bits 47:34 of the accumulator, plus the quadrant term, one register later.
- R3: When the synchronised `ofs_en_pin` is 0, the offset word adds nothing. When it is 1, the offset word is added in full.
- R4: Bit 6 of the control register at address 13 gates the serial word. This bit resets to 1 and takes effect without an update event.
- R5: `psel_pin` codes 00, 01, 10 and 11 add 0, 4096, 8192 and 12288 to `phase_out`, modulo 2^14. These are 0, 90, 180 and 270 degrees.
- R6: Addresses 0 to 5 write byte n (bits 8n+7:8n) of the base shadow. Addresses 6 to 11 write byte n-6 of the offset shadow. `ser_wr` loads `ser_word` into the serial shadow. None of these writes changes the phase step until an update event.
- R7: An update event copies all three shadows into the active words. An update event is a rising edge of the synchronised `upd_pin`, or a write of any data to address 15. The copy happens on the same clock edge that samples the address-15 write.
- R8: Each of `psel_pin`, `ofs_en_pin` and `upd_pin` passes through 2 synchroniser flops. A `psel_pin` change set up before edge k reaches `phase_out` at edge k+2.
- R9: A write sampled on the first rising edge after `rst_n` rises is ignored. This applies to both the parallel port and `ser_wr`.
- R10: The tuning sum wraps modulo 2^48. For example, a base of 0xFFFC<<32 plus an offset of 0x0008<<32 steps the phase by 1.
- R11: When a pin update event and a shadow byte write share a clock edge, the active word takes the shadow value from before that write. The new byte waits for the next update event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DDS-rate clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Parallel register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| ser_wr | input | 1 | Load strobe for the serial word shadow |
| ser_word | input | 48 | Serial frequency word, already aligned |
| upd_pin | input | 1 | Asynchronous update request, acting on its rising edge |
| ofs_en_pin | input | 1 | Asynchronous offset word enable |
| psel_pin | input | 2 | Asynchronous quadrant select |
| phase_out | output | 14 | Phase to the sine lookup |

## Verification
The update pin's synchronised edge and a byte write to a shadow register can land on the same clock edge. The bench provokes this by raising `upd_pin` and then timing a byte write so that it is sampled on the exact edge where the synchronised edge fires. It judges the result from the measured phase step. The step must keep the value from before the write. The step must move to the new value only after a later write to address 15.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int unsigned ADDR_W     = 4;
  localparam int unsigned BYTE_W     = 8;
  localparam logic [3:0]  ADDR_CTRL  = 4'd13;
  localparam logic [3:0]  ADDR_UPD   = 4'd15;
  localparam int unsigned SER_EN_BIT = 6;

  function automatic logic [47:0] base_reset_word(input int unsigned acc_w);
    logic [47:0] w;
    w = '0;
    w[acc_w-2] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/dds_pin_sync.sv
module dds_pin_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/dds_regfile.sv
module dds_regfile
  import dds_pkg::*;
#(
  parameter int unsigned ACC_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ser_wr,
  input  logic [ACC_W-1:0]  ser_word,
  input  logic              upd_s,
  output logic [ACC_W-1:0]  base_act,
  output logic [ACC_W-1:0]  ofs_act,
  output logic [ACC_W-1:0]  ser_act,
  output logic              ser_en
);
  localparam int unsigned NB = ACC_W / BYTE_W;
  localparam logic [ACC_W-1:0] BASE_RST = base_reset_word(ACC_W);

  logic             wr_ok;
  logic             wr_acc, ser_acc;
  logic             upd_d, upd_evt;
  logic [ACC_W-1:0] base_sh, ofs_sh, ser_sh;

  assign wr_acc  = wr_en & wr_ok;
  assign ser_acc = ser_wr & wr_ok;
  assign upd_evt = (upd_s & ~upd_d) | (wr_acc && wr_addr == ADDR_UPD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ok <= 1'b0;
      upd_d <= 1'b0;
    end else begin
      wr_ok <= 1'b1;
      upd_d <= upd_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_sh <= BASE_RST;
      ofs_sh  <= '0;
      ser_sh  <= '0;
      ser_en  <= 1'b1;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (wr_acc && wr_addr == ADDR_W'(b))
          base_sh[BYTE_W*b +: BYTE_W] <= wr_data;
        if (wr_acc && wr_addr == ADDR_W'(b + NB))
          ofs_sh[BYTE_W*b +: BYTE_W] <= wr_data;
      end
      if (ser_acc) ser_sh <= ser_word;
      if (wr_acc && wr_addr == ADDR_CTRL) ser_en <= wr_data[SER_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_act <= BASE_RST;
      ofs_act  <= '0;
      ser_act  <= '0;
    end else if (upd_evt) begin
      base_act <= base_sh;
      ofs_act  <= ofs_sh;
      ser_act  <= ser_sh;
    end
  end

  // R7: active words hold unless an update event occurs
  a_r7_hold_without_update: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> ($stable(base_act) && $stable(ofs_act) && $stable(ser_act)));

  // R7 / R11: on an update event, the active word takes the shadow value from before the edge
  a_r11_load_old_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> (base_act == $past(base_sh) && ofs_act == $past(ofs_sh)));

  // R9: a write on the first edge after reset release changes nothing
  a_r9_first_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> ($stable(base_sh) && $stable(ofs_sh) && $stable(ser_sh) && $stable(ser_en)));
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int unsigned ACC_W = 48,
  parameter int unsigned PH_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] base_w,
  input  logic [ACC_W-1:0] ofs_w,
  input  logic [ACC_W-1:0] ser_w,
  input  logic             ofs_en,
  input  logic             ser_en,
  input  logic [1:0]       psel,
  output logic [PH_W-1:0]  phase
);
  logic [ACC_W-1:0] tuning, acc_q;
  logic [PH_W-1:0]  quad;

  assign tuning = base_w + (ofs_en ? ofs_w : '0) + (ser_en ? ser_w : '0);
  assign quad   = {psel, {(PH_W-2){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      phase <= '0;
    end else begin
      acc_q <= acc_q + tuning;
      phase <= acc_q[ACC_W-1 -: PH_W] + quad;
    end
  end

  // R5: with a steady quadrant and a zero step, the phase output stays still
  a_r5_static_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (tuning == '0 && $stable(psel) && $stable(acc_q)) |=> $stable(phase));
endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core
  import dds_pkg::*;
#(
  parameter int unsigned ACC_W       = 48,
  parameter int unsigned PH_W        = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ser_wr,
  input  logic [ACC_W-1:0]  ser_word,
  input  logic              upd_pin,
  input  logic              ofs_en_pin,
  input  logic [1:0]        psel_pin,
  output logic [PH_W-1:0]   phase_out
);
  localparam int unsigned PIN_W = 4;

  logic [PIN_W-1:0] pins_s;
  logic             upd_s, ofs_en_s, ser_en;
  logic [1:0]       psel_s;
  logic [ACC_W-1:0] base_act, ofs_act, ser_act;

  dds_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({upd_pin, ofs_en_pin, psel_pin}),
    .q_sync(pins_s)
  );
  assign {upd_s, ofs_en_s, psel_s} = pins_s;

  dds_regfile #(.ACC_W(ACC_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ser_wr(ser_wr), .ser_word(ser_word), .upd_s(upd_s),
    .base_act(base_act), .ofs_act(ofs_act), .ser_act(ser_act),
    .ser_en(ser_en)
  );

  dds_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .base_w(base_act), .ofs_w(ofs_act), .ser_w(ser_act),
    .ofs_en(ofs_en_s), .ser_en(ser_en), .psel(psel_s),
    .phase(phase_out)
  );

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  if (SYNC_STAGES == 2) begin : g_sync_chk
    // R8: pin values arrive after two synchroniser flops
    a_r8_pin_latency: assert property (@(posedge clk) disable iff (!rst_n || age_q < 2'd2)
      (psel_s == $past(psel_pin, 2) && ofs_en_s == $past(ofs_en_pin, 2)));
  end
endmodule

// File: tb/dds_phase_core_tb.sv
module dds_phase_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        ser_wr = 1'b0;
  logic [47:0] ser_word = '0;
  logic        upd_pin = 1'b0;
  logic        ofs_en_pin = 1'b0;
  logic [1:0]  psel_pin = '0;
  logic [13:0] phase_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dds_phase_core u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ser_wr(ser_wr), .ser_word(ser_word), .upd_pin(upd_pin),
    .ofs_en_pin(ofs_en_pin), .psel_pin(psel_pin), .phase_out(phase_out)
  );

  // Each vector gives bits 47:32 of the base, offset and serial words, plus the two enables.
  localparam int NV = 6;
  localparam logic [15:0] V_BASE [NV] = '{16'h0400, 16'h0400, 16'h0400, 16'hFFFC, 16'h8000, 16'h0000};
  localparam logic [15:0] V_OFS  [NV] = '{16'h0100, 16'h0100, 16'h0100, 16'h0008, 16'h8000, 16'h0000};
  localparam logic [15:0] V_SER  [NV] = '{16'h0040, 16'h0040, 16'h0040, 16'h0000, 16'h1230, 16'h0000};
  localparam logic        V_OEN  [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic        V_SEN  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_ser(input logic [47:0] w);
    @(negedge clk);
    ser_wr = 1'b1; ser_word = w;
    @(negedge clk);
    ser_wr = 1'b0;
  endtask

  task automatic step(output logic [13:0] d);
    logic [13:0] p1;
    repeat (6) @(negedge clk);
    p1 = phase_out;
    @(negedge clk);
    d = phase_out - p1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [13:0] d, p0, exp;
    logic [15:0] sum;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(phase_out == 14'd0, "R1 phase in reset", phase_out, 0);

    // R9: a write on the first edge after release is dropped
    rst_n = 1'b1;
    wr_en = 1'b1; wr_addr = 4'd5; wr_data = 8'h00;
    @(negedge clk);
    wr_addr = 4'd15;
    @(negedge clk);
    wr_en = 1'b0;
    step(d);
    check(d == 14'd4096, "R1 R9 default step after dropped write", d, 4096);

    // Vector table: R2 R3 R4 R10
    for (int i = 0; i < NV; i++) begin
      wr(4'd4, V_BASE[i][7:0]);  wr(4'd5, V_BASE[i][15:8]);
      wr(4'd10, V_OFS[i][7:0]);  wr(4'd11, V_OFS[i][15:8]);
      load_ser({V_SER[i], 32'h0});
      wr(4'd13, V_SEN[i] ? 8'h40 : 8'h00);
      ofs_en_pin = V_OEN[i];
      wr(4'd15, 8'hA5);
      sum = V_BASE[i] + (V_OEN[i] ? V_OFS[i] : 16'h0) + (V_SEN[i] ? V_SER[i] : 16'h0);
      exp = sum[15:2];
      step(d);
      check(d == exp, $sformatf("R2 R3 R4 R10 vector %0d", i), d, exp);
    end

    // R6: a shadow write without an update leaves the step unchanged
    wr(4'd5, 8'h04);
    wr(4'd15, 8'h00);
    step(d);
    check(d == 14'h100, "R6 step before shadow write", d, 'h100);
    wr(4'd5, 8'h20);
    step(d);
    check(d == 14'h100, "R6 shadow write has no effect", d, 'h100);
    wr(4'd5, 8'h04);

    // R11: a pin update and a byte write on the same edge
    @(negedge clk); upd_pin = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'd5; wr_data = 8'h08;
    @(negedge clk); wr_en = 1'b0;
    step(d);
    check(d == 14'h100, "R11 collision keeps old shadow", d, 'h100);
    upd_pin = 1'b0;
    wr(4'd15, 8'h00);
    step(d);
    check(d == 14'h200, "R7 R11 register update loads new byte", d, 'h200);

    // R7: an update pin edge alone loads the shadows
    wr(4'd5, 8'h10);
    @(negedge clk); upd_pin = 1'b1;
    repeat (4) @(negedge clk); upd_pin = 1'b0;
    step(d);
    check(d == 14'h400, "R7 pin update", d, 'h400);
    wr(4'd5, 8'h08);
    wr(4'd15, 8'h00);

    // R4: the control bit acts without an update
    load_ser({16'h0040, 32'h0});
    wr(4'd15, 8'h00);
    step(d);
    check(d == 14'h210, "R4 serial enabled", d, 'h210);
    wr(4'd13, 8'h00);
    step(d);
    check(d == 14'h200, "R4 serial gated immediately", d, 'h200);

    // R5 and R8: quadrant offset and its timing, with a zero step
    wr(4'd5, 8'h00);
    wr(4'd15, 8'h00);
    repeat (6) @(negedge clk);
    p0 = phase_out;
    psel_pin = 2'b01;
    @(negedge clk);
    check(phase_out == p0, "R8 no change after first edge", phase_out, p0);
    @(negedge clk);
    check(phase_out == p0, "R8 no change after second edge", phase_out, p0);
    @(negedge clk);
    check(phase_out == p0 + 14'd4096, "R5 R8 quadrant at third edge", phase_out, p0 + 14'd4096);
    for (int q = 2; q < 4; q++) begin
      psel_pin = 2'(q);
      repeat (5) @(negedge clk);
      exp = p0 + 14'(q * 4096);
      check(phase_out == exp, $sformatf("R5 quadrant code %0d", q), phase_out, exp);
    end
    psel_pin = 2'b00;
    repeat (5) @(negedge clk);
    check(phase_out == p0, "R5 quadrant code 0", phase_out, p0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule